// File: doc/BRIEF.md
# Two-Level Lookahead 16-Bit Adder

This is a purely combinational 16-bit binary adder. It takes two operands and a carry-in and returns a 16-bit sum and a carry-out. No carry passes serially from one bit to the next. Each bit position produces a generate term (both operand bits set) and a propagate term (either operand bit set).

The sixteen bits form four groups of four bits each. Every group reduces its bit terms to a group generate and a group propagate. A second level of lookahead combines those group terms with the carry-in and produces the carry into every group in one step. Inside each group, a flat sum-of-products lookahead then produces the carry into each bit from the group's incoming carry. Each sum bit is the XOR of the two operand bits and that bit's carry.

The block is meant to be placed wherever a fast flat adder is needed inside a larger datapath. It has no registers and no control inputs.

Top module: `lookahead_adder16`

## Requirements
- R1: `sum_out` equals the low 16 bits of `op_a + op_b + carry_in`, where all values are unsigned and bit 0 is the least significant bit.
- R2: `carry_out` equals bit 16 of the unsigned 17-bit sum `op_a + op_b + carry_in`.
- R3: A carry-in of 1 travels through all four groups when every group only propagates. For example, `op_a`=16'hFFFF with `op_b`=0 and `carry_in`=1 gives `sum_out`=0 and `carry_out`=1.
- R4: A group whose operand nibbles generate a carry forces a carry into the next group up. For example, 16'h00F0 + 16'h0010 with carry-in 0 gives 16'h0100.
- R5: Propagate is the OR of the operand bits. A group with no generate still passes an incoming carry when every bit has at least one operand bit set. For example, 16'h0FFF + 16'h0001 gives 16'h1000.
- R6: 16'h1A33 + 16'hE5EB with carry-in 0 gives `sum_out`=16'h001E and `carry_out`=1.
- R7: Operands with every bit set and operands with alternating bits add correctly. 16'hFFFF + 16'hFFFF + 1 gives 16'hFFFF with a carry-out of 1. 16'hAAAA + 16'h5555 + 1 gives 0 with a carry-out of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Low 16 bits of the sum |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
Two carry sources can act on the same group at the same time: a carry generated inside the group, and a carry propagated into it from lower groups through the second lookahead level. Here propagate is the OR of the operand bits, so both can be true at once. The result is then correct only if the group-level OR-of-products merges them without counting either twice or dropping it. The bench provokes this overlap with a dense sweep of operands whose bytes repeat, with alternating carry-in, and with pseudo-random vectors. It judges every result against a 17-bit arithmetic sum computed in the bench.

// File: rtl/lookahead_adder16.sv
module lookahead_adder16 (
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic        carry_in,
  output logic [15:0] sum_out,
  output logic        carry_out
);
  localparam int W  = 16;
  localparam int GW = 4;
  localparam int NG = W / GW;

  logic [W-1:0]  gen, prp, cbit;
  logic [NG-1:0] ggen, gprp, gout_flat;
  logic [NG:0]   gcar;

  assign gen = op_a & op_b;
  assign prp = op_a | op_b;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    logic [GW-1:0] g, p;
    logic          ci;
    assign g  = gen[k*GW +: GW];
    assign p  = prp[k*GW +: GW];
    assign ci = gcar[k];

    assign gprp[k] = &p;
    assign ggen[k] = g[3] | (g[2] & p[3]) | (g[1] & p[2] & p[3])
                   | (g[0] & p[1] & p[2] & p[3]);

    assign cbit[k*GW]   = ci;
    assign cbit[k*GW+1] = g[0] | (p[0] & ci);
    assign cbit[k*GW+2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & ci);
    assign cbit[k*GW+3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                        | (p[2] & p[1] & p[0] & ci);
    assign gout_flat[k] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                        | (p[3] & p[2] & p[1] & g[0])
                        | (p[3] & p[2] & p[1] & p[0] & ci);
  end

  assign gcar[0] = carry_in;
  assign gcar[1] = ggen[0] | (gprp[0] & gcar[0]);
  assign gcar[2] = ggen[1] | (gprp[1] & ggen[0]) | (gprp[1] & gprp[0] & gcar[0]);
  assign gcar[3] = ggen[2] | (gprp[2] & ggen[1]) | (gprp[2] & gprp[1] & ggen[0])
                 | (gprp[2] & gprp[1] & gprp[0] & gcar[0]);
  assign gcar[4] = ggen[3] | (gprp[3] & ggen[2]) | (gprp[3] & gprp[2] & ggen[1])
                 | (gprp[3] & gprp[2] & gprp[1] & ggen[0])
                 | (gprp[3] & gprp[2] & gprp[1] & gprp[0] & gcar[0]);

  assign sum_out   = op_a ^ op_b ^ cbit;
  assign carry_out = gcar[NG];

  always_comb begin
    if (!$isunknown({op_a, op_b, carry_in})) begin
      assert_sum_R1: assert ({carry_out, sum_out} ==
                             ({1'b0, op_a} + {1'b0, op_b} + {16'b0, carry_in}))
        else $error("R1/R2 sum mismatch");
      assert_cout_R2: assert (carry_out == gout_flat[NG-1])
        else $error("R2 carry-out disagrees with flat group lookahead");
      for (int k = 0; k < NG; k++) begin
        assert_group_carry_R3: assert (gcar[k+1] == gout_flat[k])
          else $error("R3 second-level carry disagrees with group lookahead");
        assert_generate_R4: assert (!ggen[k] || gcar[k+1])
          else $error("R4 group generate did not force carry");
        assert_propagate_R5: assert (ggen[k] || !gprp[k] || (gcar[k+1] == gcar[k]))
          else $error("R5 group propagate did not pass carry");
      end
    end
  end
endmodule

// File: tb/lookahead_adder16_bench.sv
`timescale 1ns/1ps
module lookahead_adder16_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] op_a = '0, op_b = '0;
  logic carry_in = 1'b0;
  logic [15:0] sum_out;
  logic carry_out;
  int vecs = 0, errs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lookahead_adder16 u_lookahead_adder16 (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum_out(sum_out), .carry_out(carry_out)
  );

  task automatic apply(input logic [15:0] a, input logic [15:0] b,
                       input logic ci, input string req);
    logic [16:0] exp;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci;
    #1;
    exp = {1'b0, a} + {1'b0, b} + {16'b0, ci};
    vecs++;
    if ({carry_out, sum_out} !== exp) begin
      errs++;
      $display("FAIL %s a=%h b=%h ci=%b actual=%b_%h expected=%b_%h",
               req, a, b, ci, carry_out, sum_out, exp[16], exp[15:0]);
    end
  endtask

  task automatic apply_exact(input logic [15:0] a, input logic [15:0] b,
                             input logic ci, input logic [15:0] es,
                             input logic ec, input string req);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci;
    #1;
    vecs++;
    if (sum_out !== es || carry_out !== ec) begin
      errs++;
      $display("FAIL %s actual=%b_%h expected=%b_%h", req, carry_out, sum_out, ec, es);
    end
  endtask

  initial begin
    logic [15:0] lfsr_a, lfsr_b;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // zero inputs after reset: R1 / R2
    apply_exact(16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, "R1 reset-zero");
    apply_exact(16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, "R3 full propagate");
    apply_exact(16'h00F0, 16'h0010, 1'b0, 16'h0100, 1'b0, "R4 group generate");
    apply_exact(16'hF000, 16'h1000, 1'b0, 16'h0000, 1'b1, "R4 top group generate");
    apply_exact(16'h0FFF, 16'h0001, 1'b0, 16'h1000, 1'b0, "R5 OR propagate");
    apply_exact(16'h0F0F, 16'h00F1, 1'b0, 16'h1000, 1'b0, "R5 mixed propagate");
    apply_exact(16'h1A33, 16'hE5EB, 1'b0, 16'h001E, 1'b1, "R6 worked example");
    apply_exact(16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, "R7 all ones");
    apply_exact(16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1, "R7 alternating");
    apply_exact(16'hAAAA, 16'h5555, 1'b0, 16'hFFFF, 1'b0, "R7 alternating no cin");
    // dense sweep with repeated bytes: R1 / R2
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        apply(16'(i) * 16'h0101, 16'(j) * 16'h0101 ^ 16'(i << 4), 1'((i + j) & 1), "R1/R2 sweep");
    // pseudo-random vectors: R2
    lfsr_a = 16'hACE1; lfsr_b = 16'h1D2F;
    for (int n = 0; n < 4000; n++) begin
      lfsr_a = {lfsr_a[14:0], lfsr_a[15] ^ lfsr_a[13] ^ lfsr_a[12] ^ lfsr_a[10]};
      lfsr_b = {lfsr_b[14:0], lfsr_b[15] ^ lfsr_b[13] ^ lfsr_b[12] ^ lfsr_b[10]};
      apply(lfsr_a, lfsr_b, lfsr_a[0] ^ lfsr_b[3], "R2 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule